// File: doc/BRIEF.md
# Store Write Buffer with Load Forwarding

This block sits between a write-through cache and the next memory level. Stores from the processor are accepted in a single cycle into a small queue. They are then drained, oldest first, to memory over a valid/ready port. The processor does not wait for memory on every store. It only stalls when a store needs a fresh slot and every slot is taken. Stores arrive in bursts, so the queue holds several entries.

A store aimed at a word that already sits in the queue, in an entry not yet offered to memory, is folded into that entry. The enabled bytes are overwritten, and the entry keeps its place in drain order. The entry currently offered to memory is frozen. A store to its word opens a new entry behind it.

A combinational load-check port searches every queued entry for the load's word address. The youngest enabled byte wins for each byte lane. When the merged byte lanes cover the whole word, the port reports a hit and returns the merged word. When some bytes are queued but not all, it reports a conflict. The load must then wait until the buffer drains.

The drain side is a two-state machine:
- `DR_IDLE`: nothing is offered to memory.
- `DR_SEND`: the head entry is offered on the memory port and is locked.

Its transitions are:
- `T_START` (`DR_IDLE` to `DR_SEND`): taken when the queue is not empty.
- `T_HOLD` (`DR_SEND` to `DR_SEND`): taken while memory is not ready.
- `T_NEXT` (`DR_SEND` to `DR_SEND`): taken on a handshake when entries remain.
- `T_LAST` (`DR_SEND` to `DR_IDLE`): taken on a handshake that leaves the queue empty.

Top module: `wtbuf_top`

## Requirements
- R1: After reset the buffer is empty: `mem_valid`=0, `buf_full`=0, `st_ready`=1, and a load check returns `ld_hit`=0 and `ld_conflict`=0.
- R2: Stores to distinct word addresses are drained as one memory beat each, in acceptance order. Each beat carries the address, data and byte enables of its entry (`st_be[b]` covers data bits 8b+7..8b).
- R3: When DEPTH entries are queued, `buf_full`=1. A store whose address matches no open entry then sees `st_ready`=0 and is not taken until an entry drains.
- R4: A store to the address of an open (not offered) entry writes only its enabled bytes into that entry and ORs its enables into the entry's enables. It creates no entry, and the entry keeps its drain position.
- R5: The entry offered on the memory port is never changed. A store to its address opens a new entry, which drains after it.
- R6: When the queued bytes for the load address cover all byte lanes, `ld_hit`=1, `ld_conflict`=0, and `ld_data` holds, per byte lane, the byte of the youngest entry enabling it.
- R7: When some but not all byte lanes are covered, `ld_conflict`=1 and `ld_hit`=0. With no matching entry, both are 0.
- R8: Once `mem_valid` is 1, it and `mem_addr`, `mem_data` and `mem_be` hold until `mem_ready` is 1. Exactly one entry leaves per handshake.
- R9: A store that merges into an open entry is accepted (`st_ready`=1) even when `buf_full`=1, and the occupancy is unchanged.
- R10: `mem_valid` rises on the cycle after the first store into an empty, idle buffer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_ready | output | 1 | Store taken this cycle (low means stall) |
| buf_full | output | 1 | All entries occupied |
| ld_valid | input | 1 | Load check request |
| ld_addr | input | AW | Load word address |
| ld_hit | output | 1 | Whole word available in buffer |
| ld_conflict | output | 1 | Word partly buffered; drain before reading |
| ld_data | output | DW | Merged buffered word |
| mem_valid | output | 1 | Beat offered to memory |
| mem_ready | input | 1 | Memory accepts beat |
| mem_addr | output | AW | Beat word address |
| mem_data | output | DW | Beat data |
| mem_be | output | DW/8 | Beat byte enables |

## Verification
The hold-and-stable property on the memory port assumes that memory follows a valid/ready handshake. Memory may hold off `mem_ready` for any time, but the block must never withdraw a beat. The stimulus drives `mem_ready` only from the bench side, away from the clock edge. Toggling it still covers long holds, so that checking is never weakened.

The store port is assumed to keep a request up until `st_ready` is seen high. The store task only moves on after sampling acceptance. Loads are whole-word checks issued one cycle after the stores they must see.

// File: rtl/wtbuf_pkg.sv
package wtbuf_pkg;

    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_SEND = 1'b1
    } drain_state_t;

    localparam int WTB_DEF_DEPTH = 4;
    localparam int WTB_DEF_AW    = 32;
    localparam int WTB_DEF_DW    = 32;

endpackage

// File: rtl/wtbuf_queue.sv
module wtbuf_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = DW / 8,
    parameter int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    input  logic [AW-1:0]        st_addr,
    input  logic [DW-1:0]        st_data,
    input  logic [BW-1:0]        st_be,
    input  logic                 head_locked,
    input  logic                 pop,
    output logic                 st_ready,
    output logic                 enq_fire,
    output logic                 full,
    output logic [CNTW-1:0]      count,
    output logic [PTRW-1:0]      head_ptr,
    output logic [DEPTH-1:0]     e_vld,
    output logic [AW-1:0]        e_addr [DEPTH],
    output logic [DW-1:0]        e_data [DEPTH],
    output logic [BW-1:0]        e_be   [DEPTH]
);

    logic [PTRW-1:0]  tail_ptr;
    logic [DEPTH-1:0] umatch;
    logic             merge_hit;
    logic             merge_fire;

    // open-entry address match: the locked head is excluded
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            umatch[i] = e_vld[i] && (e_addr[i] == st_addr) &&
                        !(head_locked && (PTRW'(i) == head_ptr));
        end
    end

    assign merge_hit  = |umatch;
    assign full       = (count == CNTW'(DEPTH));
    assign st_ready   = merge_hit || !full;
    assign enq_fire   = st_valid && !merge_hit && !full;
    assign merge_fire = st_valid && merge_hit;

    function automatic logic [PTRW-1:0] ptr_inc(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    e_vld[g]  <= 1'b0;
                    e_addr[g] <= '0;
                    e_data[g] <= '0;
                    e_be[g]   <= '0;
                end else begin
                    if (enq_fire && (tail_ptr == PTRW'(g))) begin
                        e_vld[g]  <= 1'b1;
                        e_addr[g] <= st_addr;
                        e_data[g] <= st_data;
                        e_be[g]   <= st_be;
                    end else if (merge_fire && umatch[g]) begin
                        for (int b = 0; b < BW; b++) begin
                            if (st_be[b]) begin
                                e_data[g][b*8 +: 8] <= st_data[b*8 +: 8];
                            end
                        end
                        e_be[g] <= e_be[g] | st_be;
                    end
                    if (pop && (head_ptr == PTRW'(g))) begin
                        e_vld[g] <= 1'b0;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
        end else begin
            if (enq_fire) begin
                tail_ptr <= ptr_inc(tail_ptr);
            end
            if (pop) begin
                head_ptr <= ptr_inc(head_ptr);
            end
            unique case ({enq_fire, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_VALID_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(e_vld) == int'(count)) else $error("valid bits disagree with occupancy"); // R2
    AST_ONE_OPEN_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(umatch) <= 1) else $error("two open entries share an address"); // R4
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)) else $error("pop from empty buffer"); // R8
    AST_MERGE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_fire && !pop) |=> (count == $past(count))) else $error("merge changed occupancy"); // R9

endmodule

// File: rtl/wtbuf_forward.sv
module wtbuf_forward #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = DW / 8,
    parameter int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              ld_valid,
    input  logic [AW-1:0]     ld_addr,
    input  logic [PTRW-1:0]   head_ptr,
    input  logic [DEPTH-1:0]  e_vld,
    input  logic [AW-1:0]     e_addr [DEPTH],
    input  logic [DW-1:0]     e_data [DEPTH],
    input  logic [BW-1:0]     e_be   [DEPTH],
    output logic              ld_hit,
    output logic              ld_conflict,
    output logic [DW-1:0]     ld_data
);

    logic [BW-1:0] acc_be;
    logic [DW-1:0] acc_data;

    // walk oldest to youngest so later entries override earlier bytes
    always_comb begin
        acc_be   = '0;
        acc_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int idx;
            logic [PTRW-1:0] pi;
            idx = int'(head_ptr) + k;
            if (idx >= DEPTH) begin
                idx = idx - DEPTH;
            end
            pi = PTRW'(idx);
            if (e_vld[pi] && (e_addr[pi] == ld_addr)) begin
                for (int b = 0; b < BW; b++) begin
                    if (e_be[pi][b]) begin
                        acc_data[b*8 +: 8] = e_data[pi][b*8 +: 8];
                        acc_be[b]          = 1'b1;
                    end
                end
            end
        end
    end

    assign ld_hit      = ld_valid && (&acc_be);
    assign ld_conflict = ld_valid && (|acc_be) && !(&acc_be);
    assign ld_data     = acc_data;

endmodule

// File: rtl/wtbuf_drain_fsm.sv
module wtbuf_drain_fsm
    import wtbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic have_entry,
    input  logic more_after_pop,
    input  logic mem_ready,
    output logic mem_valid,
    output logic pop,
    output logic head_locked
);

    drain_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: begin
                if (have_entry) state_d = DR_SEND;           // T_START
            end
            DR_SEND: begin
                if (mem_ready) begin
                    state_d = more_after_pop ? DR_SEND        // T_NEXT
                                             : DR_IDLE;       // T_LAST
                end                                           // else T_HOLD
            end
            default: state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        mem_valid   = 1'b0;
        pop         = 1'b0;
        head_locked = 1'b0;
        unique case (state_q)
            DR_IDLE: ;
            DR_SEND: begin
                mem_valid   = 1'b1;
                head_locked = 1'b1;
                pop         = mem_ready;
            end
            default: ;
        endcase
    end

    AST_SEND_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DR_SEND) |-> have_entry) else $error("offering from empty buffer"); // R8

endmodule

// File: rtl/wtbuf_top.sv
module wtbuf_top
    import wtbuf_pkg::*;
#(
    parameter int DEPTH = WTB_DEF_DEPTH,
    parameter int AW    = WTB_DEF_AW,
    parameter int DW    = WTB_DEF_DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_valid,
    input  logic [AW-1:0]   st_addr,
    input  logic [DW-1:0]   st_data,
    input  logic [DW/8-1:0] st_be,
    output logic            st_ready,
    output logic            buf_full,
    input  logic            ld_valid,
    input  logic [AW-1:0]   ld_addr,
    output logic            ld_hit,
    output logic            ld_conflict,
    output logic [DW-1:0]   ld_data,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_data,
    output logic [DW/8-1:0] mem_be
);

    localparam int BW   = DW / 8;
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic             head_locked;
    logic             pop;
    logic             enq_fire;
    logic [CNTW-1:0]  count;
    logic [PTRW-1:0]  head_ptr;
    logic [DEPTH-1:0] e_vld;
    logic [AW-1:0]    e_addr [DEPTH];
    logic [DW-1:0]    e_data [DEPTH];
    logic [BW-1:0]    e_be   [DEPTH];

    wtbuf_queue #(
        .DEPTH(DEPTH), .AW(AW), .DW(DW), .BW(BW), .PTRW(PTRW), .CNTW(CNTW)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_valid   (st_valid),
        .st_addr    (st_addr),
        .st_data    (st_data),
        .st_be      (st_be),
        .head_locked(head_locked),
        .pop        (pop),
        .st_ready   (st_ready),
        .enq_fire   (enq_fire),
        .full       (buf_full),
        .count      (count),
        .head_ptr   (head_ptr),
        .e_vld      (e_vld),
        .e_addr     (e_addr),
        .e_data     (e_data),
        .e_be       (e_be)
    );

    wtbuf_drain_fsm u_drain (
        .clk           (clk),
        .rst_n         (rst_n),
        .have_entry    (count != '0),
        .more_after_pop((count > CNTW'(1)) || enq_fire),
        .mem_ready     (mem_ready),
        .mem_valid     (mem_valid),
        .pop           (pop),
        .head_locked   (head_locked)
    );

    wtbuf_forward #(
        .DEPTH(DEPTH), .AW(AW), .DW(DW), .BW(BW), .PTRW(PTRW)
    ) u_fwd (
        .ld_valid   (ld_valid),
        .ld_addr    (ld_addr),
        .head_ptr   (head_ptr),
        .e_vld      (e_vld),
        .e_addr     (e_addr),
        .e_data     (e_data),
        .e_be       (e_be),
        .ld_hit     (ld_hit),
        .ld_conflict(ld_conflict),
        .ld_data    (ld_data)
    );

    assign mem_addr = e_addr[head_ptr];
    assign mem_data = e_data[head_ptr];
    assign mem_be   = e_be[head_ptr];

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_data) && $stable(mem_be)))
        else $error("memory beat changed before handshake"); // R8
    AST_FWD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_conflict)) else $error("hit and conflict together"); // R7
    AST_START_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid && (count != '0)) |=> mem_valid) else $error("queued entry not offered"); // R10

endmodule

// File: tb/wtbuf_top_test.sv
module wtbuf_top_test;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  be;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        st_valid;
    logic [31:0] st_addr;
    logic [31:0] st_data;
    logic [3:0]  st_be;
    logic        st_ready;
    logic        buf_full;
    logic        ld_valid;
    logic [31:0] ld_addr;
    logic        ld_hit;
    logic        ld_conflict;
    logic [31:0] ld_data;
    logic        mem_valid;
    logic        mem_ready;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_be;

    int checks = 0;
    int failures = 0;
    int beats_seen = 0;
    bit done = 0;
    beat_t exp_q[$];

    always #5 clk = ~clk;

    wtbuf_top uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_ready(st_ready), .buf_full(buf_full),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_hit(ld_hit), .ld_conflict(ld_conflict), .ld_data(ld_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // driver: called at posedge+1, returns at posedge+1 after acceptance
    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        bit acc;
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        do begin
            @(negedge clk);
            acc = st_ready;
            @(posedge clk); #1;
        end while (!acc);
        st_valid = 1'b0;
    endtask

    task automatic push_exp(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        beat_t b;
        b.a = a; b.d = d; b.be = be;
        exp_q.push_back(b);
    endtask

    task automatic wait_drained();
        int n = 0;
        while (exp_q.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        @(posedge clk); #1;
        @(negedge clk);
        chk(exp_q.size() == 0, "R2 drain complete", 64'(exp_q.size()), 64'd0);
        chk(mem_valid == 1'b0, "R2 idle after drain", 64'(mem_valid), 64'd0);
        @(posedge clk); #1;
    endtask

    // monitor: scoreboard compare and hold check
    logic        pv = 0, pr = 0;
    logic [31:0] pa, pd;
    logic [3:0]  pb;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pv && !pr) begin
                chk(mem_valid && mem_addr == pa && mem_data == pd && mem_be == pb,
                    "R8 beat held", {mem_addr, mem_data}, {pa, pd});
            end
            if (mem_valid && mem_ready) begin
                beats_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected beat", 64'(mem_addr), 64'd0);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk(mem_addr == e.a && mem_data == e.d && mem_be == e.be,
                        "R2 beat order/content", {mem_addr, mem_data}, {e.a, e.d});
                    chk(mem_be == e.be, "R2 beat enables", 64'(mem_be), 64'(e.be));
                end
            end
            pv = mem_valid; pr = mem_ready; pa = mem_addr; pd = mem_data; pb = mem_be;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        rst_n = 0; st_valid = 0; st_addr = 0; st_data = 0; st_be = 0;
        ld_valid = 0; ld_addr = 0; mem_ready = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        ld_valid = 1; ld_addr = 32'h100;
        @(negedge clk);
        chk(mem_valid == 0, "R1 mem_valid", 64'(mem_valid), 64'd0);
        chk(buf_full == 0, "R1 buf_full", 64'(buf_full), 64'd0);
        chk(st_ready == 1, "R1 st_ready", 64'(st_ready), 64'd1);
        chk(ld_hit == 0 && ld_conflict == 0, "R1 load miss", {ld_hit, ld_conflict}, 64'd0);
        @(posedge clk); #1;
        ld_valid = 0;

        // expected drain order for this phase
        push_exp(32'h100, 32'h1111_1111, 4'hF);
        push_exp(32'h100, 32'hCCCC_BBBB, 4'hF);
        push_exp(32'h104, 32'h2222_3322, 4'hF);
        push_exp(32'h108, 32'h0000_00EE, 4'h1);
        push_exp(32'h10C, 32'h4444_4444, 4'hF);

        do_store(32'h100, 32'h1111_1111, 4'hF);
        @(negedge clk);
        chk(mem_valid == 0, "R10 not yet offered", 64'(mem_valid), 64'd0);
        @(posedge clk); #1;
        @(negedge clk);
        chk(mem_valid == 1 && mem_addr == 32'h100, "R10 offered next cycle", {mem_valid, mem_addr}, {1'b1, 32'h100});
        @(posedge clk); #1;

        do_store(32'h100, 32'hAAAA_BBBB, 4'b0011);   // locked head: new entry (R5)
        do_store(32'h104, 32'h2222_2222, 4'hF);
        do_store(32'h100, 32'hCCCC_DDDD, 4'b1100);   // merges into open entry (R4)
        ld_valid = 1; ld_addr = 32'h100;
        @(negedge clk);
        chk(mem_data == 32'h1111_1111 && mem_be == 4'hF, "R5 offered entry untouched", 64'(mem_data), 64'h1111_1111);
        chk(ld_hit == 1 && ld_conflict == 0, "R6 hit flags", {ld_hit, ld_conflict}, 64'd2);
        chk(ld_data == 32'hCCCC_BBBB, "R6 youngest bytes win", 64'(ld_data), 64'hCCCC_BBBB);
        @(posedge clk); #1;
        ld_valid = 0;

        do_store(32'h108, 32'h0000_00EE, 4'b0001);
        st_valid = 1; st_addr = 32'h10C; st_data = 32'h4444_4444; st_be = 4'hF;
        ld_valid = 1; ld_addr = 32'h108;
        @(negedge clk);
        chk(buf_full == 1, "R3 full at depth", 64'(buf_full), 64'd1);
        chk(st_ready == 0, "R3 new address stalls", 64'(st_ready), 64'd0);
        chk(ld_conflict == 1 && ld_hit == 0, "R7 partial is conflict", {ld_hit, ld_conflict}, 64'd1);
        @(posedge clk); #1;
        st_valid = 0;
        ld_addr = 32'h200;
        @(negedge clk);
        chk(ld_hit == 0 && ld_conflict == 0, "R7 no match", {ld_hit, ld_conflict}, 64'd0);
        chk(buf_full == 1, "R3 stalled store not taken", 64'(buf_full), 64'd1);
        @(posedge clk); #1;

        st_valid = 1; st_addr = 32'h104; st_data = 32'h0000_3300; st_be = 4'b0010;
        @(negedge clk);
        chk(st_ready == 1, "R9 merge taken when full", 64'(st_ready), 64'd1);
        @(posedge clk); #1;
        st_valid = 0;
        ld_addr = 32'h104;
        @(negedge clk);
        chk(buf_full == 1, "R9 occupancy unchanged", 64'(buf_full), 64'd1);
        chk(ld_hit == 1 && ld_data == 32'h2222_3322, "R4 merged bytes", 64'(ld_data), 64'h2222_3322);
        @(posedge clk); #1;
        ld_valid = 0;

        mem_ready = 1;
        do_store(32'h10C, 32'h4444_4444, 4'hF);
        wait_drained();
        chk(beats_seen == 5, "R2 beat count phase 1", 64'(beats_seen), 64'd5);

        // burst with intermittent memory readiness
        for (int i = 0; i < 8; i++) begin
            mem_ready = i[0];
            push_exp(32'h300 + 32'(4 * i), 32'h0101_0101 * 32'(i + 1), 4'hF);
            do_store(32'h300 + 32'(4 * i), 32'h0101_0101 * 32'(i + 1), 4'hF);
        end
        mem_ready = 1;
        wait_drained();
        chk(beats_seen == 13, "R2 beat count total", 64'(beats_seen), 64'd13);
        @(negedge clk);
        chk(buf_full == 0 && st_ready == 1, "R1 empty again", {buf_full, st_ready}, 64'd1);
        finish_run();
    end

endmodule